// File: doc/BRIEF.md
# USB Host Port Line-State Controller

This block turns three software control bits into the line state that a USB host port drives downstream. A bus-reset bit makes the port hold SE0. A resume bit makes it hold the K-state. A port-active bit marks the port as carrying traffic. Software decides how long a reset or a resume lasts. The hardware only holds the requested state for as long as the bit stays set.

A bus reset that software requests while the port is active, or while a resume is in progress, does not start at once. It waits until both conditions have cleared and then begins without further action from software. A status output shows that a reset is waiting. If software clears the reset bit while the reset is still waiting, the request is cancelled.

When high-speed operation is enabled, a running reset also raises a request to an external handshake stub and holds it until the stub acknowledges. A single write may clear the reset or resume bit and set the active bit in the same cycle. In function (device) mode the control bits are stored but never drive the lines.

Top module: `usb_host_linectl`

## Requirements
- R1: After reset all three control bits are 0, reset_deferred and hsk_req are 0, line_oe is 0 and line_state is J (2'b01). Whenever line_oe is 0, line_state reads J.
- R2: In host mode, with the port-active and resume bits at 0, writing 1 to the reset bit makes the outputs show SE0 (2'b00) with line_oe=1 after the next clock edge. The outputs stay that way until the reset bit is written back to 0.
- R3: In host mode, writing 1 to the reset bit while the port-active bit or the resume bit is 1 sets reset_deferred=1 and drives no SE0. On the edge where both bits have become 0, SE0 starts and reset_deferred returns to 0.
- R4: Clearing the reset bit while reset_deferred=1 cancels the request. reset_deferred drops to 0, and SE0 never appears, even after the port-active bit later clears.
- R5: In host mode, with the reset not running, a set resume bit drives K (2'b10) with line_oe=1 until the resume bit is written to 0.
- R6: A write of 1 to the resume bit while the port-active bit is 1 is ignored. The resume bit stays 0 and the line stays J.
- R7: One write strobe may clear the reset or resume bit and set the port-active bit in the same cycle. After that edge the cleared bit reads 0, the active bit reads 1, and the line is J with line_oe=0.
- R8: In function mode (host_mode=0) the reset and resume bits are stored and read back, but line_oe stays 0, line_state stays J and reset_deferred stays 0.
- R9: When the reset is running and the resume bit is also 1, SE0 wins over K.
- R10: With hs_enable=1, hsk_req rises on the same edge on which SE0 starts. It falls on the edge after a cycle in which hsk_ack=1, and it stays low for the rest of that reset. With hs_enable=0, hsk_req stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1 = host role, 0 = function role |
| hs_enable | input | 1 | High-speed enable; a running reset also raises the handshake request |
| wr_reset_en | input | 1 | Write strobe for the reset bit |
| wr_reset_val | input | 1 | Value written to the reset bit |
| wr_resume_en | input | 1 | Write strobe for the resume bit |
| wr_resume_val | input | 1 | Value written to the resume bit |
| wr_active_en | input | 1 | Write strobe for the port-active bit |
| wr_active_val | input | 1 | Value written to the port-active bit |
| hsk_ack | input | 1 | Acknowledge from the handshake stub |
| line_state | output | 2 | 00 SE0, 01 J, 10 K |
| line_oe | output | 1 | Line driver enable |
| reset_bit | output | 1 | Read-back of the reset bit |
| resume_bit | output | 1 | Read-back of the resume bit |
| active_bit | output | 1 | Read-back of the port-active bit |
| reset_deferred | output | 1 | A reset is requested but held off |
| hsk_req | output | 1 | Handshake request to the stub |

## Verification
The assertions assume that the stub raises hsk_ack only while hsk_req is high and for no more than one cycle per request. They also assume that host_mode and hs_enable change only while no reset or resume is driven. The stimulus holds to this. It pulses hsk_ack for a single cycle during a pending request, and it switches the mode inputs only while the line is idle J. Every write strobe lasts exactly one cycle and is driven between clock edges, so each assertion sees one clean state change per edge.

// File: rtl/usb_lc_pkg.sv
package usb_lc_pkg;

    localparam int LINE_W = 2;

    typedef enum logic [LINE_W-1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10
    } line_e;

    typedef struct packed {
        logic host;
        logic rst;
        logic rsm;
        logic act;
        logic run;
        logic def;
    } ctl_s;

    typedef struct packed {
        logic req;
        logic done;
    } hsk_s;

endpackage

// File: rtl/usb_lc_ctlbits.sv
module usb_lc_ctlbits
    import usb_lc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_mode,
    input  logic wr_reset_en,
    input  logic wr_reset_val,
    input  logic wr_resume_en,
    input  logic wr_resume_val,
    input  logic wr_active_en,
    input  logic wr_active_val,
    output ctl_s ctl_q_o,
    output logic run_next_o
);

    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.host = host_mode;
        if (wr_reset_en)  ctl_d.rst = wr_reset_val;
        // a resume may only start on an idle port
        if (wr_resume_en) ctl_d.rsm = wr_resume_val & ~ctl_q.act;
        if (wr_active_en) ctl_d.act = wr_active_val;
        // once running, the reset holds; otherwise it waits for a quiet port
        ctl_d.run = ctl_d.rst & host_mode & (ctl_q.run | (~ctl_d.act & ~ctl_d.rsm));
        ctl_d.def = ctl_d.rst & host_mode & ~ctl_d.run;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl_q_o    = ctl_q;
    assign run_next_o = ctl_d.run;

endmodule

// File: rtl/usb_lc_hsk.sv
module usb_lc_hsk
    import usb_lc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_next,
    input  logic hs_enable,
    input  logic hsk_ack,
    output logic hsk_req_o
);

    hsk_s hs_d, hs_q;

    always_comb begin
        hs_d      = hs_q;
        hs_d.done = run_next & (hs_q.done | (hs_q.req & hsk_ack));
        hs_d.req  = run_next & hs_enable & ~hs_d.done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign hsk_req_o = hs_q.req;

endmodule

// File: rtl/usb_lc_drive.sv
module usb_lc_drive
    import usb_lc_pkg::*;
(
    input  ctl_s              ctl,
    output logic [LINE_W-1:0] line_o,
    output logic              oe_o
);

    line_e ls;

    always_comb begin
        if (ctl.run) begin
            ls   = LS_SE0;
            oe_o = 1'b1;
        end else if (ctl.rsm && ctl.host) begin
            ls   = LS_K;
            oe_o = 1'b1;
        end else begin
            ls   = LS_J;
            oe_o = 1'b0;
        end
    end

    assign line_o = ls;

endmodule

// File: rtl/usb_host_linectl.sv
module usb_host_linectl
    import usb_lc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_mode,
    input  logic              hs_enable,
    input  logic              wr_reset_en,
    input  logic              wr_reset_val,
    input  logic              wr_resume_en,
    input  logic              wr_resume_val,
    input  logic              wr_active_en,
    input  logic              wr_active_val,
    input  logic              hsk_ack,
    output logic [LINE_W-1:0] line_state,
    output logic              line_oe,
    output logic              reset_bit,
    output logic              resume_bit,
    output logic              active_bit,
    output logic              reset_deferred,
    output logic              hsk_req
);

    ctl_s ctl;
    logic run_next;

    usb_lc_ctlbits u_bits (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_mode    (host_mode),
        .wr_reset_en  (wr_reset_en),
        .wr_reset_val (wr_reset_val),
        .wr_resume_en (wr_resume_en),
        .wr_resume_val(wr_resume_val),
        .wr_active_en (wr_active_en),
        .wr_active_val(wr_active_val),
        .ctl_q_o      (ctl),
        .run_next_o   (run_next)
    );

    usb_lc_hsk u_hsk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_next (run_next),
        .hs_enable(hs_enable),
        .hsk_ack  (hsk_ack),
        .hsk_req_o(hsk_req)
    );

    usb_lc_drive u_drv (
        .ctl   (ctl),
        .line_o(line_state),
        .oe_o  (line_oe)
    );

    assign reset_bit      = ctl.rst;
    assign resume_bit     = ctl.rsm;
    assign active_bit     = ctl.act;
    assign reset_deferred = ctl.def;

endmodule

// File: rtl/usb_host_linectl_chk.sv
module usb_host_linectl_chk
    import usb_lc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [LINE_W-1:0] line_state,
    input logic              line_oe,
    input logic              reset_bit,
    input logic              resume_bit,
    input logic              active_bit,
    input logic              reset_deferred,
    input logic              hsk_req,
    input logic              hsk_ack
);

    // R1
    idle_is_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |-> line_state == LS_J);

    // R2
    se0_needs_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && line_state == LS_SE0) |-> reset_bit);

    // R3
    deferred_no_se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_deferred |-> (line_state != LS_SE0 && reset_bit));

    // R5
    k_needs_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == LS_K) |-> (resume_bit && line_oe));

    // R6
    resume_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_bit) |-> !$past(active_bit));

    // R10
    req_in_se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsk_req |-> (line_state == LS_SE0 && line_oe));

    // R10
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsk_req && hsk_ack) |=> !hsk_req);

endmodule

bind usb_host_linectl usb_host_linectl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_state    (line_state),
    .line_oe       (line_oe),
    .reset_bit     (reset_bit),
    .resume_bit    (resume_bit),
    .active_bit    (active_bit),
    .reset_deferred(reset_deferred),
    .hsk_req       (hsk_req),
    .hsk_ack       (hsk_ack)
);

// File: tb/usb_host_linectl_bench.sv
module usb_host_linectl_bench;
    import usb_lc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_mode = 1'b1, hs_enable = 1'b0;
    logic wr_reset_en = 1'b0, wr_reset_val = 1'b0;
    logic wr_resume_en = 1'b0, wr_resume_val = 1'b0;
    logic wr_active_en = 1'b0, wr_active_val = 1'b0;
    logic hsk_ack = 1'b0;
    logic [1:0] line_state;
    logic line_oe, reset_bit, resume_bit, active_bit, reset_deferred, hsk_req;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    usb_host_linectl u_usb_host_linectl (.*);

    // [21:17] req, [16] host, [15] hse, [14:13] rst we/val, [12:11] rsm we/val,
    // [10:9] act we/val, [8] ack | [7] oe, [6:5] line, [4] rst, [3] rsm, [2] act, [1] def, [0] req
    localparam int NV = 20;
    localparam logic [21:0] VECS [NV] = '{
        {5'd2,  9'b1_0_11_00_00_0, 8'b1_00_1_0_0_0_0}, // R2 start reset
        {5'd2,  9'b1_0_00_00_00_0, 8'b1_00_1_0_0_0_0}, // R2 held
        {5'd9,  9'b1_0_00_11_00_0, 8'b1_00_1_1_0_0_0}, // R9 SE0 over K
        {5'd5,  9'b1_0_10_00_00_0, 8'b1_10_0_1_0_0_0}, // R5 K after reset clears
        {5'd7,  9'b1_0_00_10_11_0, 8'b0_01_0_0_1_0_0}, // R7 end resume + active
        {5'd6,  9'b1_0_00_11_00_0, 8'b0_01_0_0_1_0_0}, // R6 resume ignored
        {5'd3,  9'b1_0_11_00_00_0, 8'b0_01_1_0_1_1_0}, // R3 deferred by active
        {5'd3,  9'b1_0_00_00_10_0, 8'b1_00_1_0_0_0_0}, // R3 auto start
        {5'd7,  9'b1_0_10_00_11_0, 8'b0_01_0_0_1_0_0}, // R7 end reset + active
        {5'd1,  9'b1_0_00_00_10_0, 8'b0_01_0_0_0_0_0}, // R1 idle J
        {5'd5,  9'b1_0_00_11_00_0, 8'b1_10_0_1_0_0_0}, // R5 K
        {5'd3,  9'b1_0_11_00_00_0, 8'b1_10_1_1_0_1_0}, // R3 deferred by resume
        {5'd3,  9'b1_0_00_10_00_0, 8'b1_00_1_0_0_0_0}, // R3 start after resume ends
        {5'd2,  9'b1_0_10_00_00_0, 8'b0_01_0_0_0_0_0}, // R2 released
        {5'd8,  9'b0_0_11_00_00_0, 8'b0_01_1_0_0_0_0}, // R8 reset no drive
        {5'd8,  9'b0_0_00_11_00_0, 8'b0_01_1_1_0_0_0}, // R8 resume no drive
        {5'd8,  9'b0_0_10_10_00_0, 8'b0_01_0_0_0_0_0}, // R8 clear
        {5'd10, 9'b1_1_11_00_00_0, 8'b1_00_1_0_0_0_1}, // R10 request with SE0
        {5'd10, 9'b1_1_00_00_00_1, 8'b1_00_1_0_0_0_0}, // R10 ack drops request
        {5'd10, 9'b1_1_10_00_00_0, 8'b0_01_0_0_0_0_0}  // R10 reset ends
    };

    function automatic logic [7:0] outs();
        return {line_oe, line_state, reset_bit, resume_bit, active_bit, reset_deferred, hsk_req};
    endfunction

    task automatic check(input string tag, input logic [7:0] exp);
        total++;
        if (outs() !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b (oe,line,rst,rsm,act,def,req)", tag, outs(), exp);
        end
    endtask

    task automatic apply(input logic [8:0] s);
        {host_mode, hs_enable, wr_reset_en, wr_reset_val, wr_resume_en, wr_resume_val,
         wr_active_en, wr_active_val, hsk_ack} = s;
        @(posedge clk);
        @(negedge clk);
        {wr_reset_en, wr_resume_en, wr_active_en, hsk_ack} = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 8'b0_01_0_0_0_0_0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][16:8]);
            check($sformatf("R%0d vector %0d", VECS[i][21:17], i), VECS[i][7:0]);
        end
        // R4 cancel while deferred
        apply(9'b1_0_00_00_11_0);
        apply(9'b1_0_11_00_00_0);
        check("R4 deferred", 8'b0_01_1_0_1_1_0);
        apply(9'b1_0_10_00_00_0);
        check("R4 cancelled", 8'b0_01_0_0_1_0_0);
        apply(9'b1_0_00_00_10_0);
        check("R4 no SE0 after active clears", 8'b0_01_0_0_0_0_0);
        apply(9'b1_0_00_00_00_0);
        check("R4 still idle", 8'b0_01_0_0_0_0_0);
        // R10 no request without high speed
        apply(9'b1_0_11_00_00_0);
        check("R10 no request when hs off", 8'b1_00_1_0_0_0_0);
        // R1 reset while driving SE0
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset mid-drive", 8'b0_01_0_0_0_0_0);
        rst_n = 1'b1;
        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule